// File: doc/BRIEF.md
# Biphase Mark Audio Transmitter

This block turns one stereo pair of 16-bit audio samples per frame into the two 32-slot subframes of a consumer digital audio link. It then sends them as a single biphase-mark-coded line. A clock enable marks each half-slot state, so 128 enables make one frame. The block inserts the synchronisation preambles and counts frames within a 192-frame block. It steps through the channel-status bits one per frame and adds the validity, user and parity bits. It also does the line coding.

A producer delivers a left/right pair with a one-cycle strobe. The pair is taken in at the start of the next frame, and the last pair is sent again when no new one arrives. Software-visible settings arrive as plain inputs: four control flags, a two-bit category select, a length flag, two sample-frequency flags and two further flags. The line stays low while the transmitter is disabled, in pass-through mode or in reset. Enabling it again always restarts at the first frame of a block.

Top module: `bmt_tx`

## Requirements
- R1: Each clock with `half_ce` high and the transmitter active advances exactly one half-slot state: 64 states per subframe, 128 per frame, left subframe first. Without `half_ce`, `line_out` does not change.
- R2: Slots 0..3 of each subframe are a fixed 8-state preamble, first state first: 11101000 for the left subframe of frame 0 of each 192-frame block, 11100010 for every other left subframe, and 11100100 for every right subframe.
- R3: Slots 4..11 carry 0. Slots 12..27 carry the 16-bit sample, bit 0 in slot 12 and bit 15 in slot 27. Left samples go in the left subframe.
- R4: The validity bit (slot 28) is 0, or 1 when `mute` was high at the start of the frame. The user bit (slot 29) is always 0.
- R5: The parity bit (slot 31) makes the number of ones in slots 4..31 even, so the line is low at the end of every subframe.
- R6: In slots 4..31 the line changes level at the start of every slot, and changes again at mid-slot exactly when the bit is 1.
- R7: Slot 30 of frame n carries channel-status bit n of the block. Bits 0..3 are `cs_flags[0..3]`, bit 15 is `lbit`, bits 24/25 are `fs_flags[0]/[1]` and bits 28/29 are `cp_flags[0]/[1]`.
- R8: Channel-status bits 8..14, listed from bit 8 onward, follow `cat_sel`: 00 gives 1000000, 01 gives 1001100, 10 gives 1000100, 11 gives 0101100.
- R9: Channel-status bit 20 is 1 only in left subframes and bit 21 is 1 only in right subframes. Every other channel-status bit is 0.
- R10: A pair strobed with `smp_stb` is sent from the next frame start onward. A frame that starts with no new strobe repeats the previous pair, and the pair is 0 after reset.
- R11: `line_out` is low during reset, while `tx_en` is low and while `thru_mode` is high. Activation restarts at frame 0, slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| half_ce | input | 1 | Half-slot step enable (128 per frame) |
| tx_en | input | 1 | Transmitter enable |
| thru_mode | input | 1 | Pass-through mode; forces the line low |
| smp_stb | input | 1 | Strobe for a new sample pair |
| smp_left | input | 16 | Left sample, two's complement |
| smp_right | input | 16 | Right sample, two's complement |
| mute | input | 1 | Mute; sets validity for the frame |
| cs_flags | input | 4 | Channel-status bits 0..3 |
| cat_sel | input | 2 | Category select for bits 8..14 |
| lbit | input | 1 | Channel-status bit 15 |
| fs_flags | input | 2 | Channel-status bits 24, 25 |
| cp_flags | input | 2 | Channel-status bits 28, 29 |
| line_out | output | 1 | Biphase-mark-coded line |

## Verification
A wrong half-slot or frame count appears at the port straight away: a preamble lands in the wrong place or has the wrong pattern, and the bench decodes every subframe. A corrupted parity accumulator shows by the next parity slot as an odd count of ones, and the line is not low at the end of the subframe. A channel-status fault appears only in the one frame that carries the affected bit, so the bench runs a full block plus the first frames of the next one. It also runs short blocks for each category value.

// File: rtl/bmt_pkg.sv
package bmt_pkg;
  localparam int SUB_SLOTS  = 32;
  localparam int SLOT_W     = $clog2(SUB_SLOTS);
  localparam int HALF_W     = SLOT_W + 2;          // half, slot, subframe
  localparam int PRE_SLOTS  = 4;
  localparam int V_SLOT     = 28;
  localparam int C_SLOT     = 30;
  localparam int P_SLOT     = 31;

  localparam logic [7:0] PAT_BLOCK = 8'b11101000;
  localparam logic [7:0] PAT_LEFT  = 8'b11100010;
  localparam logic [7:0] PAT_RIGHT = 8'b11100100;

  typedef struct packed {
    logic [3:0] ctl;
    logic [1:0] cat;
    logic       lbit;
    logic [1:0] fs;
    logic [1:0] cp;
  } cs_cfg_t;

  // Channel-status bit for frame position idx; right selects the subframe.
  function automatic logic cs_bit(input logic [7:0] idx, input logic right,
                                  input cs_cfg_t c);
    logic [6:0] cat_v;   // cat_v[k] is status bit 8+k
    logic       r;
    unique case (c.cat)
      2'b00:   cat_v = 7'b0000001;
      2'b01:   cat_v = 7'b0011001;
      2'b10:   cat_v = 7'b0010001;
      default: cat_v = 7'b0011010;
    endcase
    r = 1'b0;
    if (idx < 8'd4)                        r = c.ctl[idx[1:0]];
    else if (idx >= 8'd8 && idx <= 8'd14)  r = cat_v[3'(idx - 8'd8)];
    else begin
      case (idx)
        8'd15: r = c.lbit;
        8'd20: r = ~right;
        8'd21: r = right;
        8'd24: r = c.fs[0];
        8'd25: r = c.fs[1];
        8'd28: r = c.cp[0];
        8'd29: r = c.cp[1];
        default: r = 1'b0;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/bmt_sequencer.sv
module bmt_sequencer
  import bmt_pkg::*;
#(
  parameter int BLOCK_FRAMES = 192,
  localparam int FW = $clog2(BLOCK_FRAMES)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              ce,
  output logic [HALF_W-1:0] half_idx,
  output logic [FW-1:0]     frame_idx
);
  localparam logic [FW-1:0] LAST_FRAME = FW'(BLOCK_FRAMES - 1);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      half_idx  <= '0;
      frame_idx <= '0;
    end else if (ce) begin
      half_idx <= half_idx + 1'b1;
      if (half_idx == '1)
        frame_idx <= (frame_idx == LAST_FRAME) ? '0 : frame_idx + 1'b1;
    end
  end

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
    (run && ce && half_idx == '1 && frame_idx == LAST_FRAME) |=> frame_idx == '0); // R2
  AST_FRAME_RANGE: assert property (@(posedge clk) disable iff (rst)
    frame_idx <= LAST_FRAME); // R7
endmodule

// File: rtl/bmt_payload.sv
module bmt_payload
  import bmt_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int FW       = 8,
  localparam int AUD_LSB = V_SLOT - SAMPLE_W,
  localparam int IDX_W   = $clog2(SAMPLE_W)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              smp_stb,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  input  logic              mute,
  input  cs_cfg_t           cfg,
  input  logic              sub,
  input  logic [SLOT_W-1:0] slot,
  input  logic              hf,
  input  logic [FW-1:0]     frame_idx,
  output logic              pre_bit,
  output logic              data_bit
);
  logic [SAMPLE_W-1:0] pend_l, pend_r, work_l, work_r;
  logic                mute_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_l <= '0;
      pend_r <= '0;
    end else if (smp_stb) begin
      pend_l <= smp_left;
      pend_r <= smp_right;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      work_l <= '0;
      work_r <= '0;
      mute_q <= 1'b0;
    end else if (frame_start) begin
      work_l <= pend_l;
      work_r <= pend_r;
      mute_q <= mute;
    end
  end

  logic [7:0]          pat;
  logic [2:0]          pos;
  logic [SAMPLE_W-1:0] cur;
  logic [SLOT_W-1:0]   off;

  always_comb begin
    if (sub)                   pat = PAT_RIGHT;
    else if (frame_idx == '0)  pat = PAT_BLOCK;
    else                       pat = PAT_LEFT;
    pos     = {slot[1:0], hf};
    pre_bit = pat[3'd7 - pos];
  end

  always_comb begin
    cur      = sub ? work_r : work_l;
    off      = slot - SLOT_W'(AUD_LSB);
    data_bit = 1'b0;
    if (slot >= SLOT_W'(AUD_LSB) && slot < SLOT_W'(V_SLOT))
      data_bit = cur[off[IDX_W-1:0]];
    else if (slot == SLOT_W'(V_SLOT))
      data_bit = mute_q;
    else if (slot == SLOT_W'(C_SLOT))
      data_bit = cs_bit(8'(frame_idx), sub, cfg);
  end

  AST_STB_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (smp_stb && !frame_start) ##1 frame_start |=> (work_l == $past(smp_left, 2))); // R10
endmodule

// File: rtl/bmt_line_coder.sv
module bmt_line_coder
  import bmt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic ce,
  input  logic is_pre,
  input  logic is_first,
  input  logic is_par,
  input  logic hf,
  input  logic pre_bit,
  input  logic data_bit,
  output logic line
);
  logic acc;
  logic bit_now;

  assign bit_now = is_par ? acc : data_bit;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      line <= 1'b0;
      acc  <= 1'b0;
    end else if (ce) begin
      if (is_pre) begin
        line <= pre_bit;
      end else if (!hf) begin
        line <= ~line;
      end else begin
        line <= line ^ bit_now;
        acc  <= is_first ? bit_now : (acc ^ bit_now);
      end
    end
  end

  AST_HOLD_NO_CE: assert property (@(posedge clk) disable iff (rst)
    (run && !ce) |=> $stable(line)); // R1
  AST_SUB_END_LOW: assert property (@(posedge clk) disable iff (rst)
    (run && ce && is_par && hf) |=> !line); // R5
endmodule

// File: rtl/bmt_tx.sv
module bmt_tx
  import bmt_pkg::*;
#(
  parameter int SAMPLE_W     = 16,
  parameter int BLOCK_FRAMES = 192,
  localparam int FW = $clog2(BLOCK_FRAMES)
)(
  input  logic                clk,
  input  logic                rst,
  input  logic                half_ce,
  input  logic                tx_en,
  input  logic                thru_mode,
  input  logic                smp_stb,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  input  logic                mute,
  input  logic [3:0]          cs_flags,
  input  logic [1:0]          cat_sel,
  input  logic                lbit,
  input  logic [1:0]          fs_flags,
  input  logic [1:0]          cp_flags,
  output logic                line_out
);
  logic              run;
  logic [HALF_W-1:0] half_idx;
  logic [FW-1:0]     frame_idx;
  logic              sub, hf, frame_start;
  logic [SLOT_W-1:0] slot;
  logic              pre_bit, data_bit;
  cs_cfg_t           cfg;

  assign run         = tx_en && !thru_mode;
  assign sub         = half_idx[HALF_W-1];
  assign slot        = half_idx[HALF_W-2:1];
  assign hf          = half_idx[0];
  assign frame_start = run && half_ce && (half_idx == '0);
  assign cfg         = '{ctl: cs_flags, cat: cat_sel, lbit: lbit,
                         fs: fs_flags, cp: cp_flags};

  bmt_sequencer #(.BLOCK_FRAMES(BLOCK_FRAMES)) u_seq (
    .clk(clk), .rst(rst), .run(run), .ce(half_ce),
    .half_idx(half_idx), .frame_idx(frame_idx)
  );

  bmt_payload #(.SAMPLE_W(SAMPLE_W), .FW(FW)) u_pay (
    .clk(clk), .rst(rst), .frame_start(frame_start), .smp_stb(smp_stb),
    .smp_left(smp_left), .smp_right(smp_right), .mute(mute), .cfg(cfg),
    .sub(sub), .slot(slot), .hf(hf), .frame_idx(frame_idx),
    .pre_bit(pre_bit), .data_bit(data_bit)
  );

  bmt_line_coder u_code (
    .clk(clk), .rst(rst), .run(run), .ce(half_ce),
    .is_pre(slot < SLOT_W'(PRE_SLOTS)),
    .is_first(slot == SLOT_W'(PRE_SLOTS)),
    .is_par(slot == SLOT_W'(P_SLOT)),
    .hf(hf), .pre_bit(pre_bit), .data_bit(data_bit), .line(line_out)
  );

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
    !run |=> !line_out); // R11
  AST_RESTART: assert property (@(posedge clk) disable iff (rst)
    (!run ##1 run && half_ce) |=> line_out); // R11
endmodule

// File: tb/tb_bmt_tx.sv
module tb_bmt_tx;
  logic clk = 1'b0, rst = 1'b1, half_ce = 1'b0, tx_en = 1'b0, thru_mode = 1'b0;
  logic smp_stb = 1'b0, mute = 1'b0, lbit = 1'b0;
  logic [15:0] smp_left = '0, smp_right = '0;
  logic [3:0] cs_flags = '0;
  logic [1:0] cat_sel = '0, fs_flags = '0, cp_flags = '0;
  logic line_out;

  int checks = 0, fails = 0, cyc = 0;
  logic [15:0] exp_l = '0, exp_r = '0;
  logic exp_m = 1'b0;
  logic [63:0] st;
  bit gaps = 0;

  always #10 clk = ~clk;

  bmt_tx dut (.clk(clk), .rst(rst), .half_ce(half_ce), .tx_en(tx_en),
    .thru_mode(thru_mode), .smp_stb(smp_stb), .smp_left(smp_left),
    .smp_right(smp_right), .mute(mute), .cs_flags(cs_flags), .cat_sel(cat_sel),
    .lbit(lbit), .fs_flags(fs_flags), .cp_flags(cp_flags), .line_out(line_out));

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      fails++;
      $display("FAIL watchdog: run did not end, actual=%0d expected<%0d", cyc, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_cs(input int idx, input bit right);
    logic [6:0] t;  // t[6] is bit 8
    case (cat_sel)
      2'b00: t = 7'b1000000;
      2'b01: t = 7'b1001100;
      2'b10: t = 7'b1000100;
      default: t = 7'b0101100;
    endcase
    if (idx <= 3) return cs_flags[idx];
    if (idx >= 8 && idx <= 14) return t[14 - idx];
    if (idx == 15) return lbit;
    if (idx == 20) return !right;
    if (idx == 21) return right;
    if (idx == 24 || idx == 25) return fs_flags[idx - 24];
    if (idx == 28 || idx == 29) return cp_flags[idx - 28];
    return 1'b0;
  endfunction

  // Captures one half-slot state; starts and ends at a falling edge.
  task automatic one_state(output logic v);
    logic prev;
    do begin
      half_ce = gaps ? ($urandom_range(0, 2) != 0) : 1'b1;
      prev = line_out;
      @(negedge clk);
      if (!half_ce) chk(line_out == prev, "R1", "stall", line_out, prev);
    end while (!half_ce);
    v = line_out;
  endtask

  task automatic grab_sub();
    for (int k = 0; k < 64; k++) begin
      logic v;
      one_state(v);
      st[k] = v;
    end
    half_ce = 1'b0;
  endtask

  task automatic check_sub(input int fr, input bit right, input logic [15:0] s,
                           input bit m);
    logic [7:0] pa, pe;
    logic [31:0] b;
    bit tog = 1;
    logic [15:0] aud;
    int idx;
    string tg;
    for (int k = 0; k < 8; k++) pa[7 - k] = st[k];
    pe = right ? 8'b11100100 : ((fr % 192 == 0) ? 8'b11101000 : 8'b11100010);
    chk(pa == pe, "R2", "preamble", pa, pe);
    b = '0;
    for (int sl = 4; sl < 32; sl++) begin
      if (st[2*sl] == st[2*sl - 1]) tog = 0;
      b[sl] = st[2*sl] ^ st[2*sl + 1];
    end
    chk(tog, "R6", "slot-edge transition", 0, 1);
    chk(b[11:4] == 8'h00, "R3", "aux slots", b[11:4], 0);
    aud = b[27:12];
    chk(aud == s, "R3 R10", "audio", aud, s);
    chk(b[28] == m, "R4", "validity", b[28], m);
    chk(b[29] == 1'b0, "R4", "user", b[29], 0);
    chk((^b[31:4]) == 1'b0, "R5", "parity", b[31], ~b[31]);
    idx = fr % 192;
    tg = (idx >= 8 && idx <= 14) ? "R8" : ((idx == 20 || idx == 21 || idx > 29) ? "R9" : "R7");
    chk(b[30] == exp_cs(idx, right), tg, $sformatf("status bit %0d", idx),
        b[30], exp_cs(idx, right));
  endtask

  task automatic run_block(input int nframes, input logic [1:0] cat, input bit g);
    @(negedge clk);
    tx_en = 1'b0;
    half_ce = 1'b1;
    cs_flags = 4'($urandom); lbit = 1'($urandom);
    fs_flags = 2'($urandom); cp_flags = 2'($urandom); cat_sel = cat;
    repeat (3) begin
      @(negedge clk);
      chk(line_out == 1'b0, "R11", "disabled line", line_out, 0);
    end
    half_ce = 1'b0;
    gaps = g;
    tx_en = 1'b1;
    for (int f = 0; f < nframes; f++) begin
      bit push;
      push = (f == 0) || (f > 1 && $urandom_range(0, 3) != 0);
      if (push) begin
        exp_l = (f == 0) ? 16'h0001 : 16'($urandom);
        exp_r = (f == 0) ? 16'h8000 : 16'($urandom);
        smp_left = exp_l; smp_right = exp_r;
      end
      exp_m = ($urandom_range(0, 3) == 0);
      mute = exp_m; smp_stb = push;
      @(negedge clk);
      smp_stb = 1'b0;
      smp_left = 16'($urandom); smp_right = 16'($urandom);
      grab_sub(); check_sub(f, 1'b0, exp_l, exp_m);
      grab_sub(); check_sub(f, 1'b1, exp_r, exp_m);
    end
    gaps = 0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    tx_en = 1'b1; half_ce = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk(line_out == 1'b0, "R11", "line in reset", line_out, 0);
    end
    rst = 1'b0; tx_en = 1'b0;
    run_block(194, 2'b00, 1'b1);
    @(negedge clk);
    thru_mode = 1'b1; half_ce = 1'b1;
    repeat (6) begin
      @(negedge clk);
      chk(line_out == 1'b0, "R11", "pass-through line", line_out, 0);
    end
    thru_mode = 1'b0; half_ce = 1'b0;
    run_block(40, 2'b01, 1'b0);
    run_block(40, 2'b10, 1'b0);
    run_block(40, 2'b11, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule